// File: doc/BRIEF.md
# Clock Loss-of-Signal Monitor

This block watches one input clock for missing edges. The input clock is first divided by a programmable ratio, so that the signal being watched runs slowly compared with a fixed fast reference clock. The divided signal is brought into the reference domain through a two-flop synchronizer. The monitor then counts reference cycles between transitions of that signal. If the count with no transition reaches twice the nominal number of samples per divided period, a fault is raised and the loss-of-signal alarm goes high.

Once set, the alarm is sticky. It drops only after the monitored clock has stayed fault-free for a selectable validation interval, counted in reference cycles. Any new fault during that interval holds the alarm high and restarts the interval from zero. A 2-bit mode field arms the monitor. Two codes run it. The other two codes force the alarm low and hold every counter in reset.

Top module: `clk_los_monitor`

## Requirements
- R1: The input clock is divided so that the monitored signal toggles once every `div_half` input-clock cycles (a value of 0 acts as 1). A healthy clock whose divided half-period is shorter than the gap threshold never raises the alarm; one whose half-period exceeds the threshold does.
- R2: Either edge of the synchronized divided signal restarts the gap count. A fault exists while the count of reference cycles with no edge is at least 2 × `nominal_spp`.
- R3: While the monitor is armed, a fault sets `los_alarm` on the next reference clock edge.
- R4: `los_alarm` stays high for as long as the fault persists.
- R5: After the fault ends, `los_alarm` clears once a run of fault-free reference cycles has been counted. The length of that run is picked by `valtime_sel`: 00 → VAL_T0, 01 → VAL_T1, 10 → VAL_T2, 11 → VAL_T3 cycles.
- R6: A fault during the validation interval keeps `los_alarm` high and restarts the interval from zero.
- R7: Mode codes 00 (off) and 01 (reserved) force `los_alarm` low on the next reference edge and hold the gap and validation counters at zero.
- R8: Mode codes 10 and 11 both arm the monitor with the same gap detection and validation behaviour.
- R9: After reset, `los_alarm` is low.
- R10: The gap threshold scales with `nominal_spp`. A larger value delays detection of a stopped clock accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock used for oversampling |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| mon_clk | input | 1 | Input clock being monitored |
| mon_rst_n | input | 1 | Active-low asynchronous reset, monitored-clock domain |
| div_half | input | DIV_W | Input cycles per half-period of the divided signal |
| nominal_spp | input | SPP_W | Nominal reference samples per divided period |
| mode_sel | input | 2 | 00 off, 01 reserved (off), 10 alternate (armed), 11 standard (armed) |
| valtime_sel | input | 2 | Selects one of four validation intervals |
| los_alarm | output | 1 | Sticky loss-of-signal alarm |

## Verification
The bench builds the block with the four validation intervals shortened to 20, 40, 60 and 80 reference cycles. With these values every interval can be checked on both sides of its end point, and the restart-on-fault case can be told apart from a timer that merely pauses, all within a few hundred cycles. The monitored clock runs at a quarter of the reference rate and can be gated off and on. This puts loss, recovery, a repeated loss during validation, and both armed modes within reach. With a divide setting of 2 and a nominal sample count of 16, the 32-cycle threshold is short enough that several threshold values can be compared.

// File: rtl/clm_pkg.sv
package clm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_ALT  = 2'b10,
    MODE_STD  = 2'b11
  } mon_mode_e;

  // The monitor runs only for the two upper codes.
  function automatic logic mode_armed(input logic [1:0] code);
    return (code == MODE_ALT) || (code == MODE_STD);
  endfunction

  // Gap threshold: twice the nominal samples per divided period.
  function automatic logic [16:0] gap_limit(input logic [15:0] spp);
    return {spp, 1'b0};
  endfunction

  // A half-period of zero is treated as one.
  function automatic logic [15:0] half_eff(input logic [15:0] h);
    return (h == 16'd0) ? 16'd1 : h;
  endfunction

endpackage

// File: rtl/clm_divider.sv
module clm_divider #(
  parameter int DIV_W = 16
) (
  input  logic             mon_clk,
  input  logic             mon_rst_n,
  input  logic [DIV_W-1:0] div_half,
  output logic             div_out
);
  import clm_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_w;
  logic             wrap;

  always_comb begin
    half_w = DIV_W'(half_eff(16'(div_half)));
    wrap   = (cnt_q >= half_w - DIV_W'(1));
  end

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      cnt_q   <= '0;
      div_out <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      div_out <= ~div_out;
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
    end
  end

  p_div_bound_r1: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    cnt_q < half_w);

endmodule

// File: rtl/clm_edge_sync.sv
module clm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_seen
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_seen = s2_q ^ s3_q;

endmodule

// File: rtl/clm_gap_counter.sv
module clm_gap_counter #(
  parameter int SPP_W = 16,
  localparam int GW = SPP_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          edge_seen,
  input  logic [GW-1:0] limit,
  output logic          fault,
  output logic [GW-1:0] gap_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_cnt <= '0;
    else if (!run || edge_seen) gap_cnt <= '0;
    else if (gap_cnt < limit)   gap_cnt <= gap_cnt + GW'(1);
  end

  assign fault = run && (gap_cnt >= limit);

  p_edge_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (gap_cnt == '0));

  p_held_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (gap_cnt == '0));

  p_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt <= limit) || !$stable(limit));

endmodule

// File: rtl/clm_valid_timer.sv
module clm_valid_timer #(
  parameter int VW     = 32,
  parameter int VAL_T0 = 80000,
  parameter int VAL_T1 = 4000000,
  parameter int VAL_T2 = 8000000,
  parameter int VAL_T3 = 520000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fault,
  input  logic [1:0]    valtime_sel,
  output logic          alarm,
  output logic [VW-1:0] vcnt
);
  logic [VW-1:0] lim;
  logic          done;

  always_comb begin
    case (valtime_sel)
      2'b00:   lim = VW'(VAL_T0);
      2'b01:   lim = VW'(VAL_T1);
      2'b10:   lim = VW'(VAL_T2);
      default: lim = VW'(VAL_T3);
    endcase
    done = (vcnt >= lim - VW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= 1'b0;
      vcnt  <= '0;
    end else if (!run) begin
      alarm <= 1'b0;
      vcnt  <= '0;
    end else if (fault) begin
      alarm <= 1'b1;
      vcnt  <= '0;
    end else if (alarm) begin
      if (done) begin
        alarm <= 1'b0;
        vcnt  <= '0;
      end else begin
        vcnt  <= vcnt + VW'(1);
      end
    end
  end

  p_set_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fault) |=> (alarm || !run));

  p_forced_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !alarm);

  p_fault_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (vcnt == '0));

  p_clear_after_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(alarm) && run && $past(run)) |-> (!$past(fault) && $past(done)));

endmodule

// File: rtl/clk_los_monitor.sv
module clk_los_monitor #(
  parameter int DIV_W  = 16,
  parameter int SPP_W  = 16,
  parameter int VW     = 32,
  parameter int VAL_T0 = 80000,
  parameter int VAL_T1 = 4000000,
  parameter int VAL_T2 = 8000000,
  parameter int VAL_T3 = 520000000
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             mon_clk,
  input  logic             mon_rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic [SPP_W-1:0] nominal_spp,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       valtime_sel,
  output logic             los_alarm
);
  import clm_pkg::*;

  localparam int GW = SPP_W + 1;

  logic          div_sig;
  logic          edge_seen;
  logic          armed;
  logic [GW-1:0] thr;
  logic          gap_fault;
  logic [GW-1:0] gap_cnt;
  logic [VW-1:0] vcnt;

  assign armed = mode_armed(mode_sel);
  assign thr   = GW'(gap_limit(16'(nominal_spp)));

  clm_divider #(.DIV_W(DIV_W)) u_div (
    .mon_clk  (mon_clk),
    .mon_rst_n(mon_rst_n),
    .div_half (div_half),
    .div_out  (div_sig)
  );

  clm_edge_sync u_sync (
    .clk      (ref_clk),
    .rst_n    (ref_rst_n),
    .async_in (div_sig),
    .edge_seen(edge_seen)
  );

  clm_gap_counter #(.SPP_W(SPP_W)) u_gap (
    .clk      (ref_clk),
    .rst_n    (ref_rst_n),
    .run      (armed),
    .edge_seen(edge_seen),
    .limit    (thr),
    .fault    (gap_fault),
    .gap_cnt  (gap_cnt)
  );

  clm_valid_timer #(
    .VW(VW), .VAL_T0(VAL_T0), .VAL_T1(VAL_T1), .VAL_T2(VAL_T2), .VAL_T3(VAL_T3)
  ) u_val (
    .clk        (ref_clk),
    .rst_n      (ref_rst_n),
    .run        (armed),
    .fault      (gap_fault),
    .valtime_sel(valtime_sel),
    .alarm      (los_alarm),
    .vcnt       (vcnt)
  );

  p_hold_while_fault_r4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (los_alarm && gap_fault && armed) |=> (los_alarm || !armed));

  p_timer_idle_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !los_alarm |-> (vcnt == '0));

endmodule

// File: tb/test_clk_los_monitor.sv
module test_clk_los_monitor;
  logic        ref_clk = 1'b0;
  logic        mon_clk = 1'b0;
  logic        ref_rst_n = 1'b0;
  logic        mon_rst_n = 1'b0;
  logic        mon_run = 1'b1;
  logic [15:0] div_half = 16'd2;
  logic [15:0] nominal_spp = 16'd16;
  logic [1:0]  mode_sel = 2'b11;
  logic [1:0]  valtime_sel = 2'b00;
  logic        los_alarm;

  int vectors = 0;
  int misses  = 0;

  always #5 ref_clk = ~ref_clk;
  always begin
    #20;
    if (mon_run) mon_clk = ~mon_clk;
  end

  clk_los_monitor #(
    .VAL_T0(20), .VAL_T1(40), .VAL_T2(60), .VAL_T3(80)
  ) i_clk_los_monitor (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
    .div_half(div_half), .nominal_spp(nominal_spp),
    .mode_sel(mode_sel), .valtime_sel(valtime_sel),
    .los_alarm(los_alarm)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(input logic exp, input string req);
    vectors++;
    if (los_alarm !== exp) begin
      misses++;
      $display("FAIL %s: los_alarm=%b expected %b at %0t", req, los_alarm, exp, $time);
    end
  endtask

  // Lose the clock and wait until the alarm is up.
  task automatic lose(input string req);
    mon_run = 1'b0;
    cyc(60);
    check(1'b1, req);
  endtask

  task automatic t_reset;
    cyc(1);
    check(1'b0, "R9");
    ref_rst_n = 1'b1;
    mon_rst_n = 1'b1;
    cyc(2);
    check(1'b0, "R9");
  endtask

  task automatic t_healthy;
    logic seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      cyc(1);
      if (los_alarm) seen = 1'b1;
    end
    vectors++;
    if (seen) begin
      misses++;
      $display("FAIL R1: alarm rose on healthy clock, got 1 expected 0");
    end
  endtask

  task automatic t_loss_clear;
    valtime_sel = 2'b00;
    mon_run = 1'b0;
    cyc(20);
    check(1'b0, "R2");
    cyc(40);
    check(1'b1, "R3");
    cyc(40);
    check(1'b1, "R4");
    mon_run = 1'b1;
    cyc(8);
    check(1'b1, "R5");
    cyc(52);
    check(1'b0, "R5");
  endtask

  task automatic t_valtimes;
    for (int s = 1; s < 4; s++) begin
      int lim = 20 * (s + 1);
      valtime_sel = 2'(s);
      lose("R3");
      mon_run = 1'b1;
      cyc(lim - 5);
      check(1'b1, "R5");
      cyc(35);
      check(1'b0, "R5");
    end
  endtask

  task automatic t_restart;
    logic dropped = 1'b0;
    valtime_sel = 2'b11;
    lose("R3");
    mon_run = 1'b1;
    for (int i = 0; i < 15; i++) begin cyc(1); if (!los_alarm) dropped = 1'b1; end
    mon_run = 1'b0;
    for (int i = 0; i < 50; i++) begin cyc(1); if (!los_alarm) dropped = 1'b1; end
    mon_run = 1'b1;
    for (int i = 0; i < 60; i++) begin cyc(1); if (!los_alarm) dropped = 1'b1; end
    vectors++;
    if (dropped) begin
      misses++;
      $display("FAIL R6: alarm dropped during restarted validation, got 0 expected 1");
    end
    cyc(60);
    check(1'b0, "R6");
    valtime_sel = 2'b00;
  endtask

  task automatic t_modes;
    lose("R3");
    mode_sel = 2'b00;
    cyc(1);
    check(1'b0, "R7");
    cyc(60);
    check(1'b0, "R7");
    mode_sel = 2'b01;
    cyc(60);
    check(1'b0, "R7");
    mode_sel = 2'b10;
    cyc(60);
    check(1'b1, "R8");
    mon_run = 1'b1;
    cyc(80);
    check(1'b0, "R8");
    mode_sel = 2'b11;
  endtask

  task automatic t_threshold;
    nominal_spp = 16'd40;
    cyc(100);
    check(1'b0, "R10");
    mon_run = 1'b0;
    cyc(60);
    check(1'b0, "R10");
    cyc(60);
    check(1'b1, "R10");
    mon_run = 1'b1;
    cyc(80);
    check(1'b0, "R10");
    nominal_spp = 16'd16;
  endtask

  task automatic t_ratio;
    div_half = 16'd3;
    nominal_spp = 16'd24;
    cyc(300);
    check(1'b0, "R1");
    div_half = 16'd6;
    nominal_spp = 16'd8;
    cyc(100);
    check(1'b1, "R1");
    div_half = 16'd2;
    nominal_spp = 16'd16;
    cyc(80);
    check(1'b0, "R1");
  endtask

  initial begin
    t_reset();
    t_healthy();
    t_loss_clear();
    t_valtimes();
    t_restart();
    t_modes();
    t_threshold();
    t_ratio();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #2000000;
    vectors++;
    misses++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule